// File: doc/BRIEF.md
# Packed 16-bit multiply and multiply-add unit

The unit views each of its two 64-bit operands as four signed 16-bit lanes. It multiplies the lanes pairwise and returns one of three 64-bit results. The first result packs the low half of every 32-bit lane product. The second packs the high half of every lane product. The third adds neighbouring products into two 32-bit sums. The 64-bit result is meant to replace the destination operand in the register file of a packed-integer datapath.

An operation is offered with `in_valid_i` and is taken on any rising clock edge where `in_ready_o` is high. After reset the unit is ready on every cycle, so a new operation can be issued each cycle. Each accepted operation passes through two register stages. The first stage registers the four lane products. The second stage registers the selected or summed result, together with a valid bit and an error bit.

Top module: `pmul16x4`

## Requirements
- R1: While `rst_ni` is low, `out_valid_o`, `op_err_o`, `in_ready_o` and `result_o` are all 0. `in_ready_o` is 1 on every cycle after reset is released.
- R2: Lane i of an operand occupies bits [16i+15:16i] for i = 0 to 3, and it is a signed two's-complement value.
- R3: With `op_i` = 2'b00, result lane i holds bits [15:0] of the 32-bit signed product of lane i of `src_a_i` and lane i of `src_b_i`.
- R4: With `op_i` = 2'b01, result lane i holds bits [31:16] of that same signed product.
- R5: With `op_i` = 2'b10, `result_o[31:0]` is product 0 plus product 1, and `result_o[63:32]` is product 2 plus product 3.
- R6: The sums in mode 2'b10 wrap modulo 2^32. When all four input lanes of a pair are -32768, that half of the result is 0x80000000.
- R7: An operation accepted at rising edge N appears with `out_valid_o` high after edge N+2. Operations accepted on consecutive cycles come out on consecutive cycles, in the order they were accepted.
- R8: With `op_i` = 2'b11 the result is all zeros and `op_err_o` is high, for that operation's output cycle only.
- R9: Two edges after a cycle with no accepted operation, `out_valid_o` and `op_err_o` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | An operation is offered |
| in_ready_o | output | 1 | The unit accepts an operation this cycle |
| op_i | input | 2 | 00 low half, 01 high half, 10 multiply-add, 11 invalid |
| src_a_i | input | 64 | First operand, four signed 16-bit lanes |
| src_b_i | input | 64 | Second operand, four signed 16-bit lanes |
| out_valid_o | output | 1 | `result_o` holds a new result |
| result_o | output | 64 | Packed result |
| op_err_o | output | 1 | The operation now leaving the unit had an invalid opcode |

## Verification
Two activities can fall on the same clock edge. One operation is being issued into the product stage while the previous one leaves the combine stage, and that previous one may have an invalid opcode whose error pulse must not spill onto a neighbouring result. The bench provokes this by issuing a random opcode mix, including 2'b11, on most cycles, with random gaps between operations. It also drives directed back-to-back runs in which invalid operations sit between valid ones. Each output cycle is compared against a two-deep model of the pipeline in the bench. The comparison covers the valid bit, the error bit and the full 64-bit result. The comparison also confirms that a gap in the input appears as a gap in the output.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  localparam int unsigned LANE_W_DEF = 16;
  localparam int unsigned LANES_DEF  = 4;

  typedef enum logic [1:0] {
    OP_MUL_LO = 2'b00,
    OP_MUL_HI = 2'b01,
    OP_MADD   = 2'b10,
    OP_BAD    = 2'b11
  } op_e;
endpackage

// File: rtl/pmul_lane_mul.sv
module pmul_lane_mul #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);
  logic signed [2*W-1:0] prod_s;
  assign prod_s = $signed(a_i) * $signed(b_i);
  assign prod_o = prod_s;
endmodule

// File: rtl/pmul_prod_stage.sv
module pmul_prod_stage
  import pmul_pkg::*;
#(
  parameter int unsigned W     = LANE_W_DEF,
  parameter int unsigned LANES = LANES_DEF,
  localparam int unsigned DW   = W * LANES,
  localparam int unsigned PW   = 2 * W * LANES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  op_e           op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic          vld_o,
  output op_e           op_o,
  output logic [PW-1:0] prod_o
);
  logic [PW-1:0] prod_d;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    pmul_lane_mul #(.W(W)) u_mul (
      .a_i   (a_i[l*W +: W]),
      .b_i   (b_i[l*W +: W]),
      .prod_o(prod_d[l*2*W +: 2*W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      op_o   <= OP_MUL_LO;
      prod_o <= '0;
    end else begin
      vld_o <= take_i;
      if (take_i) begin
        op_o   <= op_i;
        prod_o <= prod_d;
      end
    end
  end
endmodule

// File: rtl/pmul_combine.sv
module pmul_combine
  import pmul_pkg::*;
#(
  parameter int unsigned W     = LANE_W_DEF,
  parameter int unsigned LANES = LANES_DEF,
  localparam int unsigned DW   = W * LANES,
  localparam int unsigned PW   = 2 * W * LANES,
  localparam int unsigned PAIRS = LANES / 2
) (
  input  op_e           op_i,
  input  logic [PW-1:0] prod_i,
  output logic [DW-1:0] res_o,
  output logic          bad_o
);
  always_comb begin
    res_o = '0;
    bad_o = 1'b0;
    unique case (op_i)
      OP_MUL_LO:
        for (int l = 0; l < LANES; l++) res_o[l*W +: W] = prod_i[l*2*W +: W];
      OP_MUL_HI:
        for (int l = 0; l < LANES; l++) res_o[l*W +: W] = prod_i[l*2*W + W +: W];
      OP_MADD:
        for (int p = 0; p < PAIRS; p++)
          res_o[p*2*W +: 2*W] = prod_i[(2*p)*2*W +: 2*W] + prod_i[(2*p+1)*2*W +: 2*W];
      default: bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/pmul16x4.sv
module pmul16x4
  import pmul_pkg::*;
#(
  parameter int unsigned W     = LANE_W_DEF,
  parameter int unsigned LANES = LANES_DEF,
  localparam int unsigned DW   = W * LANES,
  localparam int unsigned PW   = 2 * W * LANES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [1:0]    op_i,
  input  logic [DW-1:0] src_a_i,
  input  logic [DW-1:0] src_b_i,
  output logic          out_valid_o,
  output logic [DW-1:0] result_o,
  output logic          op_err_o
);
  logic          take;
  logic          s1_vld;
  op_e           s1_op;
  logic [PW-1:0] s1_prod;
  logic [DW-1:0] comb_res;
  logic          comb_bad;

  assign take = in_valid_i & in_ready_o;

  pmul_prod_stage #(.W(W), .LANES(LANES)) u_prod (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .take_i(take),
    .op_i  (op_e'(op_i)),
    .a_i   (src_a_i),
    .b_i   (src_b_i),
    .vld_o (s1_vld),
    .op_o  (s1_op),
    .prod_o(s1_prod)
  );

  pmul_combine #(.W(W), .LANES(LANES)) u_comb (
    .op_i  (s1_op),
    .prod_i(s1_prod),
    .res_o (comb_res),
    .bad_o (comb_bad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_ready_o  <= 1'b0;
      out_valid_o <= 1'b0;
      op_err_o    <= 1'b0;
      result_o    <= '0;
    end else begin
      in_ready_o  <= 1'b1;
      out_valid_o <= s1_vld;
      op_err_o    <= s1_vld & comb_bad;
      if (s1_vld) result_o <= comb_res;
    end
  end
endmodule

// File: rtl/pmul16x4_chk.sv
module pmul16x4_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic [1:0]  op_i,
  input logic [63:0] src_a_i,
  input logic [63:0] src_b_i,
  input logic        out_valid_o,
  input logic [63:0] result_o,
  input logic        op_err_o
);
  a_r7_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |-> ##2 out_valid_o);

  a_r9_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_ready_o) |-> ##2 (!out_valid_o && !op_err_o));

  a_r8_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_err_o |-> (out_valid_o && result_o == 64'd0));

  a_r8_bad_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && op_i == 2'b11) |-> ##2 op_err_o);

  a_r6_madd_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && op_i == 2'b10 &&
     src_a_i == 64'h8000_8000_8000_8000 && src_b_i == 64'h8000_8000_8000_8000)
    |-> ##2 (result_o == 64'h8000_0000_8000_0000));
endmodule

bind pmul16x4 pmul16x4_chk u_chk (.*);

// File: tb/tb_pmul16x4.sv
`timescale 1ns/1ps
module tb_pmul16x4;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  op = 2'b00;
  logic [63:0] a = '0, b = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        op_err;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pmul16x4 dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .op_i(op), .src_a_i(a), .src_b_i(b), .out_valid_o(out_valid),
    .result_o(result), .op_err_o(op_err)
  );

  // expectation pipeline: e1 = issued last negedge, e2 = due now
  logic        e1_v = 0, e2_v = 0;
  logic [63:0] e1_r = 0, e2_r = 0;
  logic        e1_e = 0, e2_e = 0;
  string       e1_t = "R7", e2_t = "R7";

  // lanes are bits [16l+15:16l], signed (R2)
  function automatic logic [64:0] model(logic [1:0] o, logic [63:0] x, logic [63:0] y);
    logic signed [31:0] p [4];
    logic [63:0] r = '0;
    for (int l = 0; l < 4; l++) p[l] = $signed(x[16*l +: 16]) * $signed(y[16*l +: 16]);
    case (o)
      2'b00: for (int l = 0; l < 4; l++) r[16*l +: 16] = p[l][15:0];
      2'b01: for (int l = 0; l < 4; l++) r[16*l +: 16] = p[l][31:16];
      2'b10: begin r[31:0] = p[0] + p[1]; r[63:32] = p[2] + p[3]; end
      default: return {1'b1, 64'd0};
    endcase
    return {1'b0, r};
  endfunction

  function automatic string tag_of(logic [1:0] o);
    case (o)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string t, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic check_out();
    chk(e2_v ? "R7" : "R9", {63'd0, out_valid}, {63'd0, e2_v});
    chk(e2_v ? "R8" : "R9", {63'd0, op_err}, {63'd0, e2_v & e2_e});
    if (e2_v) chk(e2_t, result, e2_r);
  endtask

  // call at a negedge: check, then drive a new stimulus
  task automatic step(logic v, logic [1:0] o, logic [63:0] x, logic [63:0] y, string t);
    logic [64:0] m;
    check_out();
    e2_v = e1_v; e2_r = e1_r; e2_e = e1_e; e2_t = e1_t;
    m = model(o, x, y);
    e1_v = v; e1_r = m[63:0]; e1_e = m[64]; e1_t = (t == "") ? tag_of(o) : t;
    in_valid = v; op = o; a = x; b = y;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {60'd0, out_valid, op_err, in_ready, 1'b0}, 64'd0);
    chk("R1", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {63'd0, in_ready}, 64'd1);

    // directed corners
    step(1, 2'b10, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, "R6");
    step(1, 2'b01, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, "R4");
    step(1, 2'b00, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, "R3");
    step(1, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, "R8");
    step(1, 2'b01, 64'hFFFF_7FFF_0001_FFFF, 64'hFFFF_7FFF_8000_0002, "R2");
    step(1, 2'b11, 64'h0, 64'h0, "R8");
    step(0, 2'b11, 64'h0, 64'h0, "R9");
    step(1, 2'b10, 64'h7FFF_8000_7FFF_7FFF, 64'h7FFF_7FFF_7FFF_7FFF, "R6");
    step(1, 2'b00, 64'h0003_FFFE_0100_0001, 64'h0005_0007_0100_FFFF, "R3");

    // random mix with gaps
    for (int i = 0; i < 3000; i++) begin
      logic v = ($urandom % 5) != 0;
      step(v, 2'($urandom), {$urandom, $urandom}, {$urandom, $urandom}, "");
    end
    step(0, 2'b00, 64'h0, 64'h0, "R9");
    step(0, 2'b00, 64'h0, 64'h0, "R9");
    check_out();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule